// File: doc/BRIEF.md
# Serial Word-Buffered EEPROM Slave

This block is the slave side of a two-wire serial bus (clock line and open-drain data line) in front of a 512-bit nonvolatile store. The store is 32 rows of 16 bits and is modelled as a register file. The store can only be reached over the bus. The block samples both bus lines with its own system clock and finds START, STOP and clock edges from those samples. It drives the data line low through a single output enable.

Every transaction opens with a control byte. This byte gives the direction, a two-bit access mode and a row number. When the control byte arrives, the block copies the addressed row into a 16-bit buffer. Bytes then move between the bus and this buffer in the byte order that the mode selects. A write carries one or two data bytes. The STOP that follows starts a programming cycle, which clears the row and then stores the buffer into it. A read may run on for any length, and the row can step up or down after each word. While programming is under way the block ignores the bus entirely. A master can therefore poll for completion by sending control bytes until one is acknowledged.

The programming time is the parameter `PROG_CYCLES`, counted in system clocks. Its default is about 10 ms at 50 MHz, and a simulation can set it much shorter.

Top module: `serial_word_eeprom`

## Requirements
- R1: After reset, `sda_oe` is low and every row of the store holds 0x0000.
- R2: The first byte after START is the control byte, received MSB first. Bit 7 is the direction (0 write, 1 read), bits 6:5 are the mode and bits 4:0 are the row. When no programming is under way, the block acknowledges the control byte by pulling the data line low in the ninth clock.
- R3: Modes 00, 10 and 11 transfer the high byte of a word first, then the low byte. This holds for both reads and writes.
- R4: Mode 01 transfers the low byte of a word first, then the high byte. This holds for both reads and writes.
- R5: The buffer is loaded from the addressed row when the control byte arrives. A write of a single data byte therefore changes only the byte it lands in, and the other byte of the row keeps its old value.
- R6: A STOP that follows at least one received data byte of a write starts programming. A STOP that follows a write control byte with no data byte starts no programming, so the next control byte is acknowledged at once.
- R7: In mode 10 a read steps to row+1 after both bytes of a word have been sent and acknowledged. Row 31 wraps to row 0.
- R8: In mode 11 a read steps to row-1 after each word. Row 0 wraps to row 31.
- R9: In modes 00 and 01 a read that continues past one word sends the same row again, in the same byte order.
- R10: For `PROG_CYCLES` clocks after a programming STOP, the block ignores the bus. It does not drive the data line, it acknowledges no control byte and no data byte reaches the store. Once the cycle ends, control bytes are acknowledged again.
- R11: In one write, a third or later data byte is not acknowledged and does not change the stored word.
- R12: When the master answers a read byte with NACK, the block releases the data line and sends no more data until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen by the slave |
| sda_i | input | 1 | Bus data line as seen by the slave (wired-AND level) |
| sda_oe | output | 1 | High pulls the bus data line low |

## Verification
The bench tests the wrap of the row counter at both ends. It reads up across row 31 and down across row 0, and a counter that saturated or used the wrong width would return the wrong word on the third read. The bench also does single-byte writes in both byte orders. If the buffer were not loaded from the row, the untouched byte would come back as zero, and a swapped lane would corrupt the wrong half. Around programming, the bench checks three things: a poll made right after the STOP must be refused, a write sent during the busy time must leave the store unchanged, and a STOP after a data-less write must start no cycle. A block that counted that STOP as a write would refuse the next poll. Finally, the bench sends a third data byte and expects it to be refused, and it expects the data line to be released after the master NACKs a read byte.

// File: rtl/serial_word_eeprom.sv
module serial_word_eeprom #(
  parameter int PROG_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int ROW_W = 5;
  localparam int ROWS  = 1 << ROW_W;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  localparam logic [3:0] S_IDLE  = 4'd0;
  localparam logic [3:0] S_CTRL  = 4'd1;
  localparam logic [3:0] S_CACK0 = 4'd2;
  localparam logic [3:0] S_CACK1 = 4'd3;
  localparam logic [3:0] S_WR    = 4'd4;
  localparam logic [3:0] S_WACK0 = 4'd5;
  localparam logic [3:0] S_WACK1 = 4'd6;
  localparam logic [3:0] S_RD    = 4'd7;
  localparam logic [3:0] S_RACK  = 4'd8;
  localparam logic [3:0] S_RACK1 = 4'd9;
  localparam logic [3:0] S_HOLD  = 4'd10;

  logic             scl_q, sda_q;
  logic [3:0]       st;
  logic [2:0]       cnt;
  logic [7:0]       sh;
  logic             rnw, bsel, ack;
  logic [1:0]       mode, nbytes;
  logic [ROW_W-1:0] row;
  logic [15:0]      wbuf;
  logic [CW-1:0]    prog_cnt;
  logic [15:0]      mem [ROWS];

  wire busy     = prog_cnt != '0;
  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire in_write = (st == S_WR) || (st == S_WACK0) || (st == S_WACK1);
  wire [7:0] rx = {sh[6:0], sda_i};
  wire lo_first = mode == 2'b01;
  wire [7:0] tx_pick = (bsel ^ lo_first) ? wbuf[7:0] : wbuf[15:8];
  wire [ROW_W-1:0] next_row = (mode == 2'b10) ? row + 1'b1 :
                              (mode == 2'b11) ? row - 1'b1 : row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rnw      <= 1'b0;
      bsel     <= 1'b0;
      ack      <= 1'b0;
      mode     <= '0;
      nbytes   <= '0;
      row      <= '0;
      wbuf     <= '0;
      prog_cnt <= '0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (busy) begin
        prog_cnt <= prog_cnt - 1'b1;
        st       <= S_IDLE;
        sda_oe   <= 1'b0;
        if (prog_cnt == CW'(1)) mem[row] <= wbuf;
      end else if (start_c) begin
        st     <= S_CTRL;
        cnt    <= '0;
        nbytes <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (in_write && !rnw && nbytes != 2'd0) begin
          prog_cnt <= CW'(PROG_CYCLES);
          mem[row] <= '0;
        end
      end else begin
        case (st)
          S_CTRL: if (scl_rise) begin
            sh  <= rx;
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              rnw  <= rx[7];
              mode <= rx[6:5];
              row  <= rx[4:0];
              wbuf <= mem[rx[4:0]];
              bsel <= 1'b0;
              st   <= S_CACK0;
            end
          end
          S_CACK0: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_CACK1;
          end
          S_CACK1: if (scl_fall) begin
            cnt <= '0;
            if (rnw) begin
              sh     <= tx_pick;
              sda_oe <= ~tx_pick[7];
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
          S_WR: if (scl_rise) begin
            sh  <= rx;
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              if (nbytes != 2'd2) begin
                if (nbytes[0] ^ lo_first) wbuf[7:0] <= rx;
                else                      wbuf[15:8] <= rx;
                nbytes <= nbytes + 1'b1;
                ack    <= 1'b1;
              end else begin
                ack <= 1'b0;
              end
              st <= S_WACK0;
            end
          end
          S_WACK0: if (scl_fall) begin
            sda_oe <= ack;
            st     <= S_WACK1;
          end
          S_WACK1: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WR;
          end
          S_RD: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              cnt    <= cnt + 1'b1;
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          S_RACK: if (scl_rise) begin
            if (sda_i) begin
              st <= S_HOLD;
            end else begin
              bsel <= ~bsel;
              if (bsel) begin
                row  <= next_row;
                wbuf <= mem[next_row];
              end
              st <= S_RACK1;
            end
          end
          S_RACK1: if (scl_fall) begin
            sh     <= tx_pick;
            sda_oe <= ~tx_pick[7];
            cnt    <= '0;
            st     <= S_RD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_word_eeprom_chk.sv
module serial_word_eeprom_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        sda_i,
  input logic        busy,
  input logic        stop_c,
  input logic        scl_rise,
  input logic [3:0]  st,
  input logic [1:0]  nbytes,
  input logic [1:0]  mode,
  input logic        bsel,
  input logic [4:0]  row,
  input logic [15:0] wbuf
);
  wire wr_phase = (st == 4'd4) || (st == 4'd5) || (st == 4'd6);
  wire word_done = (st == 4'd8) && scl_rise && !sda_i && bsel && !busy;

  a_r6_prog_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_c && wr_phase && nbytes != 2'd0) |=> busy);

  a_r6_zero_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_c && nbytes == 2'd0) |=> !busy);

  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  a_r10_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wbuf) && $stable(row)));

  a_r11_byte_cap: assert property (@(posedge clk) disable iff (!rst_n)
    nbytes != 2'd3);

  a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && mode == 2'b10) |=> row == 5'($past(row) + 5'd1));

  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && mode == 2'b11) |=> row == 5'($past(row) - 5'd1));

  a_r9_same_row: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !mode[1]) |=> $stable(row));

  a_r12_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd10) |-> !sda_oe);
endmodule

bind serial_word_eeprom serial_word_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .sda_i(sda_i), .busy(busy),
  .stop_c(stop_c), .scl_rise(scl_rise), .st(st), .nbytes(nbytes),
  .mode(mode), .bsel(bsel), .row(row), .wbuf(wbuf)
);

// File: tb/sim_serial_word_eeprom.sv
module sim_serial_word_eeprom;
  localparam int PROG = 300;
  localparam int Q    = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic [15:0] model [32];

  always #10 clk = ~clk;

  serial_word_eeprom #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; scl = 1'b1; qwait;
    sda_m = 1'b0; qwait;
    scl = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait;
    scl = 1'b1; qwait;
    sda_m = 1'b1; qwait;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait;
    scl = 1'b1; qwait; qwait;
    scl = 1'b0; qwait;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait;
    scl = 1'b1; qwait;
    b = sda_line; qwait;
    scl = 1'b0; qwait;
  endtask

  task automatic put_byte(input logic [7:0] d, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!give_ack);
  endtask

  function automatic logic [7:0] ctl(bit rd, logic [1:0] md, logic [4:0] r);
    return {rd, md, r};
  endfunction

  task automatic wait_ready(output int nacks, output bit ready);
    bit a;
    nacks = 0; ready = 0;
    for (int i = 0; i < 40 && !ready; i++) begin
      bus_start; put_byte(ctl(0, 2'b00, 5'd0), a); bus_stop;
      if (a) ready = 1; else nacks++;
    end
  endtask

  task automatic do_write(input logic [1:0] md, input logic [4:0] r, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input string tag);
    bit a; int nk; bit rdy;
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    bus_start;
    put_byte(ctl(0, md, r), a);
    check({tag, " R2 ctrl ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(bs[i], a);
      if (i < 2) begin
        check({tag, " data ack"}, a, 1);
        if ((i == 0) ^ (md == 2'b01)) model[r][15:8] = bs[i];
        else                          model[r][7:0]  = bs[i];
      end else begin
        check({tag, " R11 extra byte nack"}, a, 0);
      end
    end
    bus_stop;
    wait_ready(nk, rdy);
    check({tag, " R10 ready after programming"}, rdy, 1);
  endtask

  task automatic do_read(input logic [1:0] md, input logic [4:0] r, input int n, input string tag);
    bit a; logic [7:0] d, e; logic [4:0] rr; bit lo;
    rr = r;
    bus_start;
    put_byte(ctl(1, md, r), a);
    check({tag, " R2 ctrl ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n - 1);
      lo = (i % 2 == 0) ? (md == 2'b01) : (md != 2'b01);
      e  = lo ? model[rr][7:0] : model[rr][15:8];
      check($sformatf("%s byte %0d", tag, i), d, e);
      if (i % 2 == 1) begin
        if (md == 2'b10) rr = rr + 5'd1;
        else if (md == 2'b11) rr = rr - 5'd1;
      end
    end
    for (int k = 0; k < 3; k++) begin
      qwait;
      check({tag, " R12 released after nack"}, sda_oe, 0);
    end
    bus_stop;
  endtask

  task automatic t_reset;
    check("R1 sda_oe after reset", sda_oe, 0);
    do_read(2'b00, 5'd7, 2, "R1 row7 zero");
    do_read(2'b00, 5'd31, 2, "R1 row31 zero");
  endtask

  task automatic t_hi_first;
    do_write(2'b00, 5'd5, 2, 8'hA1, 8'hB2, 8'h00, "R3 write");
    check("R3 model", model[5], 16'hA1B2);
    do_read(2'b00, 5'd5, 2, "R3 read");
  endtask

  task automatic t_lo_first;
    do_write(2'b01, 5'd9, 2, 8'h34, 8'h12, 8'h00, "R4 write");
    check("R4 model", model[9], 16'h1234);
    do_read(2'b00, 5'd9, 2, "R4 read hi-first");
    do_read(2'b01, 5'd9, 2, "R4 read lo-first");
  endtask

  task automatic t_one_byte;
    do_write(2'b01, 5'd5, 1, 8'h77, 8'h00, 8'h00, "R5 write lo");
    do_read(2'b00, 5'd5, 2, "R5 keep hi");
    do_write(2'b00, 5'd9, 1, 8'hC3, 8'h00, 8'h00, "R5 write hi");
    do_read(2'b00, 5'd9, 2, "R5 keep lo");
  endtask

  task automatic t_busy;
    bit a; int nk; bit rdy;
    bus_start;
    put_byte(ctl(0, 2'b00, 5'd10), a);
    put_byte(8'h5A, a); put_byte(8'hA5, a);
    bus_stop;
    model[10] = 16'h5AA5;
    bus_start;
    put_byte(ctl(0, 2'b00, 5'd11), a);
    check("R10 ctrl nack while busy", a, 0);
    put_byte(8'hEE, a); put_byte(8'hFF, a);
    bus_stop;
    wait_ready(nk, rdy);
    check("R10 ack returns", rdy, 1);
    do_read(2'b00, 5'd11, 2, "R10 ignored write");
    do_read(2'b00, 5'd10, 2, "R10 programmed word");
    bus_start;
    put_byte(ctl(0, 2'b00, 5'd10), a);
    put_byte(8'h66, a);
    bus_stop;
    model[10][15:8] = 8'h66;
    wait_ready(nk, rdy);
    check("R10 first poll refused", nk > 0, 1);
    check("R10 ready", rdy, 1);
  endtask

  task automatic t_zero;
    bit a; int nk; bit rdy;
    bus_start;
    put_byte(ctl(0, 2'b00, 5'd12), a);
    bus_stop;
    wait_ready(nk, rdy);
    check("R6 no programming on zero data", nk, 0);
    do_read(2'b00, 5'd12, 2, "R6 row unchanged");
  endtask

  task automatic t_third;
    do_write(2'b00, 5'd20, 3, 8'h11, 8'h22, 8'h33, "R11 write");
    check("R11 model", model[20], 16'h1122);
    do_read(2'b00, 5'd20, 2, "R11 read");
  endtask

  task automatic t_inc;
    do_write(2'b10, 5'd30, 2, 8'h30, 8'h03, 8'h00, "R7 fill30");
    do_write(2'b10, 5'd31, 2, 8'h31, 8'h13, 8'h00, "R7 fill31");
    do_write(2'b10, 5'd0,  2, 8'h00, 8'hF0, 8'h00, "R7 fill0");
    do_read(2'b10, 5'd30, 6, "R7 wrap up");
  endtask

  task automatic t_dec;
    do_write(2'b11, 5'd1, 2, 8'h01, 8'h10, 8'h00, "R8 fill1");
    do_read(2'b11, 5'd1, 6, "R8 wrap down");
  endtask

  task automatic t_same;
    do_read(2'b01, 5'd9, 4, "R9 repeat lo-first");
    do_read(2'b00, 5'd5, 4, "R9 repeat hi-first");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_hi_first;
    t_lo_first;
    t_one_byte;
    t_busy;
    t_zero;
    t_third;
    t_inc;
    t_dec;
    t_same;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule